// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the standard management registers, addresses 0 to 6, of an Ethernet physical-layer device. It sits behind a simple parallel access port with a 5-bit address, a write strobe, 16-bit write data and a combinational 16-bit read path. An external serial management engine would drive this port.

Register 0 is the only writable register. It holds a loopback enable, a forced speed, an auto-negotiation enable and a duplex bit, and drives each of them to the datapath as a control output. Its top bit starts a self-clearing software reset. The reset restores the control defaults at once. It then keeps a busy flag high for a timed interval of about one microsecond, counted in clock cycles from the clock frequency parameter. While the flag is high, every control write is refused.

The effective speed output has a fixed priority. A fibre strap input forces 100 Mb/s. Otherwise the negotiated speed is used while auto-negotiation is on. In all other cases the stored forced speed is used. Registers 1 to 6 return fixed reset values and ignore writes.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After the hardware reset input, addresses 0 to 6 read 0x3100, 0x7849, 0x0000, 0x8201, 0x01E1, 0x0080 and 0x0000, with the fibre input low.
- R2: Reads from any address from 7 to 31 return 0x0000.
- R3: Writes to addresses 1 to 6 have no effect on the values read back.
- R4: A write to address 0 with bit 15 set, made while reset_busy is low, raises reset_busy on the next clock edge. reset_busy then stays high for exactly RST_CYCLES = CLK_MHZ*RESET_NS/1000 cycles (25 by default). Bit 15 of address 0 always reads 0.
- R5: A software reset restores the register 0 fields to their defaults: loopback 0, forced speed 1, auto-negotiation 1, duplex 1.
- R6: While reset_busy is high, writes to address 0 change nothing, and that includes bit 15.
- R7: Bit 14 of address 0 sets and clears the loopback enable, and loopback_en follows it. A write with bit 15 at 0 never starts a reset.
- R8: Bit 12 (auto-negotiation enable) and bit 8 (full duplex) of address 0 are stored, read back and driven on an_enable and full_duplex.
- R9: With fibre_mode low, bit 13 stores the forced speed (1 means 100 Mb/s) and reads back the stored value. speed_100 equals an_speed_100 when bit 12 is 1, and the stored bit 13 otherwise.
- R10: With fibre_mode high, bit 13 reads 1 and speed_100 is 1. Writes to bit 13 leave the stored forced speed unchanged, which becomes visible once fibre_mode drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_addr | input | 5 | Register address for read and write |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for reg_addr |
| fibre_mode | input | 1 | Fibre strap; forces 100 Mb/s and locks bit 13 |
| an_speed_100 | input | 1 | Speed result from auto-negotiation (1 means 100 Mb/s) |
| loopback_en | output | 1 | Transmit-to-receive nibble loopback enable |
| speed_100 | output | 1 | Effective speed to the datapath |
| an_enable | output | 1 | Auto-negotiation enable |
| full_duplex | output | 1 | Duplex selection |
| reset_busy | output | 1 | High during the software reset interval |

## Verification
On every cycle the checker verifies the following:
- The reset interval is exactly as long as required.
- A reset write starts the busy flag on the next edge.
- The control outputs hold still while the flag is high.
- The fibre strap forces the speed.
- Bit 15 and addresses above 6 read zero.

Some behaviour needs a sequence of accesses, so only the bench scenarios can show it:
- The reset values of all seven registers.
- Writes to the read-only registers leaving them unchanged.
- The stored forced speed surviving a write made under the fibre strap.
- The speed mux choosing between the negotiated and the stored value.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int REG_W = 16;

   // control register field positions (decoded by the datapath and software)
   localparam int B_SWRST = 15;
   localparam int B_LOOP  = 14;
   localparam int B_SPEED = 13;
   localparam int B_ANEN  = 12;
   localparam int B_DUPX  = 8;

   localparam logic [REG_W-1:0] STAT_VAL  = 16'h7849;
   localparam logic [REG_W-1:0] ID_HI_VAL = 16'h0000;
   localparam logic [REG_W-1:0] ID_LO_VAL = 16'h8201;
   localparam logic [REG_W-1:0] ADV_VAL   = 16'h01E1;
   localparam logic [REG_W-1:0] LPA_VAL   = 16'h0080;
   localparam logic [REG_W-1:0] EXP_VAL   = 16'h0000;

   typedef struct packed {
      logic loop;
      logic speed;
      logic an_en;
      logic duplex;
   } ctrl_t;

   localparam ctrl_t CTRL_DEF = '{loop: 1'b0, speed: 1'b1, an_en: 1'b1, duplex: 1'b1};

endpackage

// File: rtl/phy_swrst_timer.sv
module phy_swrst_timer #(
   parameter int CYCLES = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= CNT_W'(CYCLES - 1);
      end
   end
endmodule

// File: rtl/phy_bmcr_reg.sv
module phy_bmcr_reg
   import phy_mgmt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             busy,
   input  logic             speed_lock,
   output logic             swrst_start,
   output ctrl_t            ctrl
);
   logic accept;

   assign accept      = wr_sel && !busy;
   assign swrst_start = accept && wr_data[B_SWRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= CTRL_DEF;
      end else if (swrst_start) begin
         ctrl <= CTRL_DEF;
      end else if (accept) begin
         ctrl.loop   <= wr_data[B_LOOP];
         ctrl.an_en  <= wr_data[B_ANEN];
         ctrl.duplex <= wr_data[B_DUPX];
         if (!speed_lock) ctrl.speed <= wr_data[B_SPEED];
      end
   end
endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
   import phy_mgmt_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  ctrl_t             ctrl,
   input  logic              speed_lock,
   output logic [REG_W-1:0]  rd_data
);
   logic [REG_W-1:0] ctrl_word;

   always_comb begin
      ctrl_word          = '0;
      ctrl_word[B_LOOP]  = ctrl.loop;
      ctrl_word[B_SPEED] = ctrl.speed | speed_lock;
      ctrl_word[B_ANEN]  = ctrl.an_en;
      ctrl_word[B_DUPX]  = ctrl.duplex;
   end

   always_comb begin
      case (addr)
         ADDR_W'(0): rd_data = ctrl_word;
         ADDR_W'(1): rd_data = STAT_VAL;
         ADDR_W'(2): rd_data = ID_HI_VAL;
         ADDR_W'(3): rd_data = ID_LO_VAL;
         ADDR_W'(4): rd_data = ADV_VAL;
         ADDR_W'(5): rd_data = LPA_VAL;
         ADDR_W'(6): rd_data = EXP_VAL;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
   import phy_mgmt_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int CLK_MHZ   = 25,
   parameter int RESET_NS  = 1000,
   parameter bit HAS_FIBRE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              fibre_mode,
   input  logic              an_speed_100,
   output logic              loopback_en,
   output logic              speed_100,
   output logic              an_enable,
   output logic              full_duplex,
   output logic              reset_busy
);
   localparam int RST_CYCLES = (CLK_MHZ * RESET_NS) / 1000;

   if (RST_CYCLES < 1) begin : g_bad_interval
      $error("reset interval rounds to zero cycles");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address too narrow for seven registers");
   end

   logic  fibre_eff;
   logic  swrst_start;
   logic  wr_sel;
   ctrl_t ctrl;

   if (HAS_FIBRE) begin : g_fibre
      assign fibre_eff = fibre_mode;
   end else begin : g_copper
      assign fibre_eff = 1'b0;
   end

   assign wr_sel = wr_en && (reg_addr == '0);

   phy_swrst_timer #(.CYCLES(RST_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (swrst_start),
      .busy  (reset_busy)
   );

   phy_bmcr_reg u_bmcr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .busy        (reset_busy),
      .speed_lock  (fibre_eff),
      .swrst_start (swrst_start),
      .ctrl        (ctrl)
   );

   phy_mgmt_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
      .addr       (reg_addr),
      .ctrl       (ctrl),
      .speed_lock (fibre_eff),
      .rd_data    (rd_data)
   );

   assign loopback_en = ctrl.loop;
   assign an_enable   = ctrl.an_en;
   assign full_duplex = ctrl.duplex;
   assign speed_100   = fibre_eff | (ctrl.an_en ? an_speed_100 : ctrl.speed);
endmodule

// File: rtl/phy_mgmt_regfile_chk.sv
module phy_mgmt_regfile_chk #(
   parameter int ADDR_W     = 5,
   parameter int RST_CYCLES = 25,
   parameter bit HAS_FIBRE  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              wr_en,
   input logic [15:0]       wr_data,
   input logic [15:0]       rd_data,
   input logic              fibre_mode,
   input logic              loopback_en,
   input logic              speed_100,
   input logic              an_enable,
   input logic              full_duplex,
   input logic              reset_busy
);
   logic [15:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy_cnt <= '0;
      else if (reset_busy) busy_cnt <= busy_cnt + 1'b1;
      else                 busy_cnt <= '0;
   end

   p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reset_busy |-> busy_cnt < 16'(RST_CYCLES));

   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset_busy) |-> busy_cnt == 16'(RST_CYCLES));

   p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == '0 && wr_data[15] && !reset_busy) |=> reset_busy);

   p_bit15_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == '0) |-> !rd_data[15]);

   p_defaults_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_busy) |-> (!loopback_en && an_enable && full_duplex));

   p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_busy && $past(reset_busy)) |->
         ($stable(loopback_en) && $stable(an_enable) && $stable(full_duplex)));

   p_high_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr > ADDR_W'(6)) |-> rd_data == 16'h0000);

   p_fibre_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_FIBRE && fibre_mode) |-> (speed_100 && (reg_addr != '0 || rd_data[13])));
endmodule

bind phy_mgmt_regfile phy_mgmt_regfile_chk #(
   .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES), .HAS_FIBRE(HAS_FIBRE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
   .wr_data(wr_data), .rd_data(rd_data), .fibre_mode(fibre_mode),
   .loopback_en(loopback_en), .speed_100(speed_100), .an_enable(an_enable),
   .full_duplex(full_duplex), .reset_busy(reset_busy)
);

// File: tb/phy_mgmt_regfile_tb.sv
module phy_mgmt_regfile_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_MHZ    = 25;
   localparam int RESET_NS   = 1000;
   localparam int RST_CYC    = (CLK_MHZ * RESET_NS) / 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        fibre_mode = 1'b0;
   logic        an_speed_100 = 1'b0;
   logic        loopback_en, speed_100, an_enable, full_duplex, reset_busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   bit m_lb, m_spd, m_an, m_dup, m_busy;
   int m_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_mgmt_regfile #(.CLK_MHZ(CLK_MHZ), .RESET_NS(RESET_NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .fibre_mode(fibre_mode),
      .an_speed_100(an_speed_100), .loopback_en(loopback_en),
      .speed_100(speed_100), .an_enable(an_enable),
      .full_duplex(full_duplex), .reset_busy(reset_busy)
   );

   function automatic logic [15:0] exp_rd(input logic [4:0] a, input bit fib);
      case (a)
         5'd0: return {1'b0, m_lb, (fib | m_spd), m_an, 3'b000, m_dup, 8'h00};
         5'd1: return 16'h7849;
         5'd2: return 16'h0000;
         5'd3: return 16'h8201;
         5'd4: return 16'h01E1;
         5'd5: return 16'h0080;
         5'd6: return 16'h0000;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic bit exp_speed(input bit fib, input bit ans);
      return fib ? 1'b1 : (m_an ? ans : m_spd);
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_defaults();
      m_lb = 0; m_spd = 1; m_an = 1; m_dup = 1;
   endtask

   task automatic hw_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      model_defaults();
      m_busy = 0; m_cnt = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one clock cycle: drive at negedge, check reads, clock, check outputs
   task automatic step(input bit we, input logic [4:0] a, input logic [15:0] d,
                       input bit fib, input bit ans, input string tag);
      bit old_busy;
      wr_en = we; reg_addr = a; wr_data = d; fibre_mode = fib; an_speed_100 = ans;
      #1;
      check(tag, rd_data, exp_rd(a, fib));
      check(fib ? "R10 speed" : "R9 speed", 16'(speed_100), 16'(exp_speed(fib, ans)));
      @(posedge clk);
      old_busy = m_busy;
      if (m_busy) begin
         if (m_cnt == 0) m_busy = 0;
         else m_cnt--;
      end
      if (we && a == 5'd0 && !old_busy) begin
         if (d[15]) begin
            model_defaults();
            m_busy = 1; m_cnt = RST_CYC - 1;
         end else begin
            m_lb = d[14]; m_an = d[12]; m_dup = d[8];
            if (!fib) m_spd = d[13];
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      check("R7 loopback", 16'(loopback_en), 16'(m_lb));
      check("R8 an_enable", 16'(an_enable), 16'(m_an));
      check("R8 full_duplex", 16'(full_duplex), 16'(m_dup));
      check("R4 reset_busy", 16'(reset_busy), 16'(m_busy));
   endtask

   function automatic string tag_for(input logic [4:0] a);
      if (a == 5'd0) return "R9 reg0";
      if (a > 5'd6)  return "R2 high address";
      return "R3 read-only";
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      logic [15:0] rnd;
      bit fib;
      rnd = 16'($urandom(32'd20240611));
      hw_reset();

      // R1 defaults and R2 high address
      for (int a = 0; a < 7; a++) step(0, 5'(a), 16'h0, 0, 0, "R1 default");
      step(0, 5'd7, 16'h0, 0, 0, "R2 high address");
      step(0, 5'd31, 16'h0, 0, 0, "R2 high address");

      // R3 writes to read-only registers
      for (int a = 1; a < 7; a++) begin
         step(1, 5'(a), 16'hFFFF, 0, 0, "R3 write");
         step(0, 5'(a), 16'h0, 0, 0, "R3 readback");
      end

      // R7 loopback set and clear, bit15=0 never resets
      step(1, 5'd0, 16'h4000, 0, 0, "R7 set");
      step(0, 5'd0, 16'h0, 0, 0, "R7 read set");
      step(1, 5'd0, 16'h0000, 0, 1, "R7 clear");
      step(0, 5'd0, 16'h0, 0, 1, "R7 read clear");

      // R9 forced speed vs negotiated speed, R8 fields
      step(1, 5'd0, 16'h2100, 0, 0, "R9 force 100");
      step(0, 5'd0, 16'h0, 0, 0, "R9 read forced");
      step(1, 5'd0, 16'h1000, 0, 1, "R8 an on");
      step(0, 5'd0, 16'h0, 0, 1, "R9 negotiated 1");
      step(0, 5'd0, 16'h0, 0, 0, "R9 negotiated 0");

      // R10 fibre strap
      step(1, 5'd0, 16'h2000, 0, 0, "R10 stored 1");
      step(1, 5'd0, 16'h0000, 1, 0, "R10 write under fibre");
      step(0, 5'd0, 16'h0, 1, 0, "R10 read fibre");
      step(0, 5'd0, 16'h0, 0, 0, "R10 stored kept");

      // R4/R5/R6 software reset
      step(1, 5'd0, 16'h4000, 0, 0, "R7 pre-reset");
      step(1, 5'd0, 16'h8000, 0, 0, "R4 start");
      n = 0;
      while (reset_busy && n < 100) begin
         n++;
         step(1, 5'd0, (n % 2) ? 16'h4000 : 16'h8000, 0, 0, "R6 lockout");
      end
      check("R4 busy length", 16'(n), 16'(RST_CYC));
      step(0, 5'd0, 16'h0, 0, 0, "R5 defaults after reset");
      step(1, 5'd0, 16'h0000, 0, 0, "R7 zero bit15");
      check("R7 no reset from zero", 16'(reset_busy), 16'h0);

      // constrained random
      fib = 0;
      for (int i = 0; i < 1500; i++) begin
         logic [4:0] a;
         logic [15:0] d;
         a = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'($urandom % 8);
         d = 16'($urandom);
         if ($urandom % 12 != 0) d[15] = 1'b0;
         if ($urandom % 25 == 0) fib = ~fib;
         step(($urandom % 2) == 1, a, d, fib, ($urandom % 2) == 1, tag_for(a));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule